// File: doc/BRIEF.md
# Gamepad serial scan controller

This block reads the 16-bit button word of a serial gamepad for a host processor. Software writes a command byte to a control register, polls a busy flag, and then fetches the result as two byte registers. On the pad side the block drives a latch strobe and a shift clock and samples a single serial data line. The pad presents its first bit as soon as the latch strobe rises, so the first sample is taken before any clock edge. Fifteen more bits are clocked out on rising clock edges. The line is active low, so every sample is inverted before it is stored.

The clock half-period is a parameter counted in system clock cycles, so a test build can run a scan in a few dozen cycles. The result registers are loaded in one step when the last of the 16 samples is taken. Until then they keep the previous word, and software never sees a half-shifted value.

Top module: `gpad_scan`

## Requirements
- R1: After reset the low byte (offset 0), the high byte (offset 1) and the control register (offset 2) all read 0, pad_latch is low and pad_clk is high.
- R2: Writing exactly 0x84 to offset 2 while idle starts a scan. Control bit 1 (busy) reads 1 from the cycle after the write for exactly 31 × HALF_CYCLES cycles, then reads 0.
- R3: Each sample is inverted before storage: a low level on pad_data gives a 1 in the result and a high level gives a 0. After a scan, offset 1 holds result bits 15..8 and offset 0 holds bits 7..0.
- R4: The sample taken while the latch strobe is high, before any clock edge, lands in result bit 15. Each later sample lands one bit lower, so the last one (the battery status) lands in bit 0 and the one before it in bit 1.
- R5: While a scan is running, offsets 0 and 1 keep the word from the previous completed scan.
- R6: A scan raises pad_latch for one half-period with pad_clk high, then gives exactly 15 rising edges on pad_clk, and ends with pad_clk high. pad_clk is never low while pad_latch is high, and both pad lines are idle (latch low, clock high) whenever busy is 0.
- R7: Writing exactly 0x80 to offset 2 aborts a running scan. Busy and done read 0 from the next cycle, the pad lines return to idle, and the result bytes are left unchanged.
- R8: Writes to offsets 0 and 1, control values other than 0x80 and 0x84, and a 0x84 written during a scan have no effect: the scan length and the result are the same as without them.
- R9: Control bit 0 (done) becomes 1 when a scan completes. It is cleared by an accepted start and by an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 low byte, 1 high byte, 2 control |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_latch | output | 1 | Latch strobe to the pad |
| pad_clk | output | 1 | Shift clock to the pad, high at rest |
| pad_data | input | 1 | Serial data from the pad, active low |

## Verification
Each bit of the bit counter and each phase of the sequencer has a visible effect on the pad lines or the result. A wrong phase shows up at once as a clock low during the latch strobe. A bit counter that is off by one gives a scan length that differs from 31 half-periods and a clock edge count other than 15, and both are seen by the end of the same scan. An error in the sample path shows up as a single wrong result bit after completion. Walking-one and walking-zero patterns tie every result bit to one particular position in the serial stream.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LATCH  = 2'd1,
    PH_CLK_LO = 2'd2,
    PH_CLK_HI = 2'd3
  } phase_e;

  localparam int SCAN_BITS = 16;

  localparam logic [1:0] OFS_LO  = 2'd0;
  localparam logic [1:0] OFS_HI  = 2'd1;
  localparam logic [1:0] OFS_CTL = 2'd2;

  localparam logic [7:0] CMD_START = 8'h84;
  localparam logic [7:0] CMD_ABORT = 8'h80;
endpackage

// File: rtl/gpad_halfper.sv
module gpad_halfper #(
  parameter int HALF_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (restart || tick || !run) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gpad_seq.sv
module gpad_seq
  import gpad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_abort,
  input  logic tick,
  output logic restart,
  output logic sample,
  output logic commit,
  output logic busy,
  output logic pad_latch,
  output logic pad_clk
);
  localparam int BIT_W = $clog2(SCAN_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SCAN_BITS - 1);

  phase_e           phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    restart = 1'b0;
    sample  = 1'b0;
    commit  = 1'b0;
    if (cmd_abort) begin
      phase_d = PH_IDLE;
      restart = 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: if (cmd_start) begin
          phase_d = PH_LATCH;
          bit_d   = '0;
          restart = 1'b1;
        end
        PH_LATCH: if (tick) begin
          sample  = 1'b1;
          bit_d   = bit_q + 1'b1;
          phase_d = PH_CLK_LO;
        end
        PH_CLK_LO: if (tick) phase_d = PH_CLK_HI;
        PH_CLK_HI: if (tick) begin
          sample = 1'b1;
          if (bit_q == BIT_LAST) begin
            commit  = 1'b1;
            phase_d = PH_IDLE;
          end else begin
            bit_d   = bit_q + 1'b1;
            phase_d = PH_CLK_LO;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign pad_latch = (phase_q == PH_LATCH);
  assign pad_clk   = (phase_q != PH_CLK_LO);
endmodule

// File: rtl/gpad_capture.sv
module gpad_capture
  import gpad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample,
  input  logic                 commit,
  input  logic                 pad_data,
  output logic [SCAN_BITS-1:0] result
);
  logic [SCAN_BITS-2:0] shift_q, shift_d;
  logic [SCAN_BITS-1:0] result_q, result_d;
  logic                 bit_in;

  assign bit_in = ~pad_data;

  always_comb begin
    shift_d  = shift_q;
    result_d = result_q;
    if (sample) shift_d  = {shift_q[SCAN_BITS-3:0], bit_in};
    if (commit) result_d = {shift_q, bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      result_q <= '0;
    end else begin
      shift_q  <= shift_d;
      result_q <= result_d;
    end
  end

  assign result = result_q;
endmodule

// File: rtl/gpad_scan.sv
module gpad_scan
  import gpad_pkg::*;
#(
  parameter int HALF_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       pad_latch,
  output logic       pad_clk,
  input  logic       pad_data
);
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic ctl_wr, cmd_start, cmd_abort;
  assign ctl_wr    = reg_wr && (reg_addr == OFS_CTL);
  assign cmd_start = ctl_wr && (reg_wdata == CMD_START);
  assign cmd_abort = ctl_wr && (reg_wdata == CMD_ABORT);

  logic tick, restart, sample, commit, busy;
  logic [SCAN_BITS-1:0] result;

  gpad_halfper #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .restart(restart), .tick(tick)
  );

  gpad_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_start(cmd_start), .cmd_abort(cmd_abort),
    .tick(tick), .restart(restart), .sample(sample), .commit(commit),
    .busy(busy), .pad_latch(pad_latch), .pad_clk(pad_clk)
  );

  gpad_capture u_cap (
    .clk(clk), .rst_n(rst_sync_n), .sample(sample), .commit(commit),
    .pad_data(pad_data), .result(result)
  );

  logic done_q, done_d;
  always_comb begin
    done_d = done_q;
    if (commit)                          done_d = 1'b1;
    if (cmd_abort || (cmd_start && !busy)) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  always_comb begin
    case (reg_addr)
      OFS_LO:  reg_rdata = result[7:0];
      OFS_HI:  reg_rdata = result[15:8];
      OFS_CTL: reg_rdata = {6'b0, busy, done_q};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/gpad_scan_chk.sv
module gpad_scan_chk
  import gpad_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           reg_addr,
  input logic                 reg_wr,
  input logic [7:0]           reg_wdata,
  input logic                 busy,
  input logic                 done,
  input logic [SCAN_BITS-1:0] result,
  input logic                 pad_latch,
  input logic                 pad_clk
);
  logic ctl_wr;
  assign ctl_wr = reg_wr && (reg_addr == OFS_CTL);

  assert_latch_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch |-> pad_clk);

  assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pad_clk && !pad_latch));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(result));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata == CMD_START && !busy) |=> busy);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata == CMD_ABORT) |=> (!busy && !done && $stable(result)));

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata == CMD_START && !busy) |=> !done);
endmodule

bind gpad_scan gpad_scan_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .busy(busy), .done(done_q), .result(result),
  .pad_latch(pad_latch), .pad_clk(pad_clk)
);

// File: tb/gpad_scan_test.sv
module gpad_scan_test;
  localparam int HALF = 2;
  localparam int SCAN_LEN = 31 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pad_latch, pad_clk, pad_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  logic [15:0] pat = 16'h0000;
  logic [4:0]  idx = 5'd0;
  int          rises = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  gpad_scan #(.HALF_CYCLES(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_latch(pad_latch),
    .pad_clk(pad_clk), .pad_data(pad_data)
  );

  // pad model: pressed bits in pat, line driven active low, MSB first
  always @(posedge pad_latch or posedge pad_clk) begin
    if (pad_latch) begin
      idx   <= 5'd0;
      rises <= 0;
    end else begin
      idx   <= idx + 5'd1;
      rises <= rises + 1;
    end
  end
  assign pad_data = (idx < 5'd16) ? ~pat[4'(15 - idx)] : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rd_result(output logic [15:0] r);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    r = {hi, lo};
  endtask

  // mid_op: 0 none, 1 second start, 2 abort, 3 junk writes
  task automatic run_scan(input logic [15:0] p, input int mid_op, input int mid_at,
                          output int dur, output int lat, output logic [15:0] prev);
    logic [7:0]  c;
    logic [15:0] r;
    int t0, n;
    rd_result(prev);
    pat = p;
    wr(2'd2, 8'h84);
    t0 = cyc; n = 0; lat = 0;
    forever begin
      rd(2'd2, c);
      if (!c[1] || n > 1000) break;
      if (pad_latch) lat++;
      if (n == 10 && mid_op == 0) begin
        rd_result(r);
        check(r == prev, "R5 result held during scan", r, prev);
      end
      if (n == mid_at && mid_op == 1) wr(2'd2, 8'h84);
      else if (n == mid_at && mid_op == 2) wr(2'd2, 8'h80);
      else if (n == mid_at && mid_op == 3) begin
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h5A);
        n++;
      end else @(negedge clk);
      n++;
    end
    dur = cyc - t0;
  endtask

  initial begin
    int dur, lat;
    logic [15:0] prev, r, p;
    logic [7:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_result(r);
    check(r == 16'h0, "R1 result after reset", r, 0);
    rd(2'd2, c);
    check(c == 8'h00, "R1 control after reset", c, 0);
    check(!pad_latch && pad_clk, "R1 idle pad lines", {pad_latch, pad_clk}, 2'b01);

    // R8 ignored writes while idle
    wr(2'd2, 8'h04); wr(2'd2, 8'h85); wr(2'd1, 8'hFF);
    repeat (3) @(negedge clk);
    rd(2'd2, c);
    check(c == 8'h00, "R8 no start on other values", c, 0);
    rd_result(r);
    check(r == 16'h0, "R8 data offsets not writable", r, 0);

    // R2 R3 R4 R6 R9 sweep: walking ones, walking zeros, all clear, all set
    for (int k = 0; k < 34; k++) begin
      if (k < 16)       p = 16'h1 << k;
      else if (k < 32)  p = ~(16'h1 << (k - 16));
      else if (k == 32) p = 16'h0000;
      else              p = 16'hFFFF;
      run_scan(p, 0, -1, dur, lat, prev);
      check(dur == SCAN_LEN, "R2 busy length", dur, SCAN_LEN);
      rd_result(r);
      check(r == p, "R3 R4 inverted MSB-first result", r, p);
      check(lat == HALF, "R6 latch high one half-period", lat, HALF);
      check(rises == 15, "R6 fifteen clock rises", rises, 15);
      check(pad_clk && !pad_latch, "R6 ends with clock high", {pad_latch, pad_clk}, 2'b01);
      rd(2'd2, c);
      check(c == 8'h01, "R9 done set, busy clear", c, 8'h01);
    end

    // R4 first sample (before any clock edge) goes to bit 15, battery to bit 0
    run_scan(16'h8001, 0, -1, dur, lat, prev);
    rd(2'd1, c);
    check(c == 8'h80, "R4 first sample in bit 15", c, 8'h80);
    rd(2'd0, c);
    check(c == 8'h01, "R4 last sample in bit 0", c, 8'h01);

    // R8 second start during scan ignored
    run_scan(16'h3C96, 1, 20, dur, lat, prev);
    check(dur == SCAN_LEN, "R8 restart ignored length", dur, SCAN_LEN);
    rd_result(r);
    check(r == 16'h3C96, "R8 restart ignored result", r, 16'h3C96);

    // R8 junk writes during scan ignored
    run_scan(16'hC35A, 3, 15, dur, lat, prev);
    check(dur == SCAN_LEN, "R8 junk ignored length", dur, SCAN_LEN);
    rd_result(r);
    check(r == 16'hC35A, "R8 junk ignored result", r, 16'hC35A);

    // R7 abort mid-scan, R9 done cleared
    run_scan(16'h1234, 2, 25, dur, lat, prev);
    check(dur == 26, "R7 abort ends scan next cycle", dur, 26);
    rd_result(r);
    check(r == 16'hC35A, "R7 result unchanged by abort", r, 16'hC35A);
    rd(2'd2, c);
    check(c == 8'h00, "R7 R9 busy and done clear", c, 0);
    check(pad_clk && !pad_latch, "R7 pad lines idle", {pad_latch, pad_clk}, 2'b01);

    // R9 done cleared by accepted start
    run_scan(16'h0F0F, 0, -1, dur, lat, prev);
    wr(2'd2, 8'h84);
    rd(2'd2, c);
    check(c == 8'h02, "R9 start clears done", c, 8'h02);
    wr(2'd2, 8'h80);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule